// File: doc/BRIEF.md
# Cascaded Mapped Interrupt Controller

This block collects level-sensitive interrupt requests into two 8-bit local groups and presents each group's masked result on its own CPU interrupt line. A third 8-bit group, the mapped group, is not wired to the CPU directly. It is gated by two independent map masks. Each gated result collapses to a single bit that takes a fixed seat inside one of the local groups: bit 7 of group 0 and bit 3 of group 1. Software numbers the sources 0–7 for group 0, 8–15 for group 1, 16–23 for the mapped group through map mask A, and 24–31 for the mapped group through map mask B.

Two timer channels are modelled as one-cycle tick inputs. Each tick sets a sticky flag that appears in local group 1, at bit 0 for timer 0 and bit 1 for timer 1. Software clears the flags through a write-only clear register. One of the group 0 inputs is commonly used as a FIFO-busy indication, which software polls until it reads zero. For that reason the status bits follow their inputs with no latching.

Software reaches the block over a synchronous byte bus. A read is registered, so its data appears one cycle after the address. The register offsets are 0 group 0 status, 1 group 0 mask, 2 group 1 status, 3 group 1 mask, 4 mapped status, 5 map mask A, 6 map mask B and 7 timer clear.

Top module: `casc_irq_ctrl`

## Requirements
- R1: The group 0 status (offset 0) and group 1 status (offset 2) follow their source inputs level-sensitively. Once an input drops, its bit reads zero. Bus writes to status offsets 0, 2 and 4 change nothing.
- R2: Group 0 status bit 7 equals the OR of (mapped status AND map mask A). The grp0_src[7] input has no effect.
- R3: Group 1 status bit 3 equals the OR of (mapped status AND map mask B). The grp1_src[3] input has no effect.
- R4: The mapped status at offset 4 mirrors map_src. The four masks are byte-wide, readable and writable: group 0 at offset 1, group 1 at offset 3, map mask A at offset 5 and map mask B at offset 6.
- R5: cpu_irq0 is the OR of (group 0 status AND group 0 mask), and cpu_irq1 is the same for group 1. Each output is registered, so it changes on the first clock edge after its cause is present. An all-zero mask keeps the output low.
- R6: A one-cycle tmr0_tick sets group 1 status bit 0, and tmr1_tick sets bit 1. Each flag stays set until it is cleared. The grp1_src[1:0] inputs have no effect.
- R7: Offset 7 is a write-only clear register. Writing bit 0 clears the timer 0 flag, writing bit 1 clears the timer 1 flag, and writing 0x03 clears both. Bits 7:2 are ignored, and a read of offset 7 returns 0.
- R8: A tick that arrives in the same cycle as a clear of its flag leaves the flag set.
- R9: Read data appears on bus_rdata one cycle after the read command and holds until the next read. Addresses 8 and above read 0, and writes to them change nothing.
- R10: Reset clears all masks, both timer flags, both interrupt outputs and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Registered read data |
| grp0_src | input | W (8) | Group 0 level sources (bit 7 unused) |
| grp1_src | input | W (8) | Group 1 level sources (bits 3, 1, 0 unused) |
| map_src | input | W (8) | Mapped group level sources |
| tmr0_tick | input | 1 | Timer 0 event pulse |
| tmr1_tick | input | 1 | Timer 1 event pulse |
| cpu_irq0 | output | 1 | Interrupt line for group 0 |
| cpu_irq1 | output | 1 | Interrupt line for group 1 |

## Verification
The bench drives source inputs onto the bit positions that the cascade and timer flags take over. A design that let those inputs through would show stray status bits or false interrupts. It drives a tick and a clear in the same cycle, where a design that gave the clear priority would lose a timer event. It also writes clear values with only the high bits set, which a loose decode would treat as a clear. It samples the interrupt line just before and just after the edge that follows a source change, catching a design whose output is combinational or one cycle late. It writes to addresses above 7 and then reads the masks back, which exposes a decoder that ignores the upper address bits.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

   // Byte offsets of the register file; the low three address bits select one.
   typedef enum logic [2:0] {
      RA_STAT0  = 3'd0,
      RA_MASK0  = 3'd1,
      RA_STAT1  = 3'd2,
      RA_MASK1  = 3'd3,
      RA_MSTAT  = 3'd4,
      RA_MMASKA = 3'd5,
      RA_MMASKB = 3'd6,
      RA_TCLR   = 3'd7
   } reg_addr_e;

   localparam int unsigned REG_SEL_W = 3;
   localparam int unsigned N_MASKS   = 4;
   localparam int unsigned N_TIMERS  = 2;
   localparam int unsigned N_CASC    = 2;

endpackage

// File: rtl/casc_irq_cascade.sv
// Gates the mapped status byte with each map mask and reduces each result to one bit.
module casc_irq_cascade #(
   parameter int unsigned W     = 8,
   parameter int unsigned N_OUT = 2
) (
   input  logic [W-1:0]            mstat,
   input  logic [N_OUT-1:0][W-1:0] mmask,
   output logic [N_OUT-1:0]        casc
);

   for (genvar g = 0; g < N_OUT; g++) begin : g_way
      logic [W-1:0] gated;
      assign gated   = mstat & mmask[g];
      assign casc[g] = |gated;
   end

endmodule

// File: rtl/casc_irq_tick_latch.sv
// Sticky event flags: a tick sets, a clear strobe with its bit resets, the tick wins.
module casc_irq_tick_latch #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] tick,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_bits,
   output logic [N-1:0] flag
);

   for (genvar t = 0; t < N; t++) begin : g_chan
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (tick[t]) begin
            flag_q <= 1'b1;
         end else if (clr_stb && clr_bits[t]) begin
            flag_q <= 1'b0;
         end
      end
      assign flag[t] = flag_q;
   end

endmodule

// File: rtl/casc_irq_group.sv
// One local group: status assembly (external levels plus injected bits), masking, CPU line.
module casc_irq_group #(
   parameter int unsigned   W        = 8,
   parameter logic [W-1:0]  INJ_MASK = '0,
   parameter bit            IRQ_REG  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic [W-1:0] inj_val,
   input  logic [W-1:0] mask,
   output logic [W-1:0] stat,
   output logic         irq
);

   logic [W-1:0] pend;
   logic         any_pend;

   assign stat     = (src & ~INJ_MASK) | (inj_val & INJ_MASK);
   assign pend     = stat & mask;
   assign any_pend = |pend;

   if (IRQ_REG) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_pend;
      end
      assign irq = irq_q;
   end else begin : g_comb_out
      assign irq = any_pend;
   end

endmodule

// File: rtl/casc_irq_regs.sv
// Byte bus decode, mask storage, timer-clear strobe and registered read mux.
module casc_irq_regs
   import casc_irq_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic [W-1:0]      stat0,
   input  logic [W-1:0]      stat1,
   input  logic [W-1:0]      mstat,
   output logic [W-1:0]      mask0,
   output logic [W-1:0]      mask1,
   output logic [W-1:0]      mmask_a,
   output logic [W-1:0]      mmask_b,
   output logic              clr_stb,
   output logic [W-1:0]      clr_bits
);

   localparam reg_addr_e MASK_AT [N_MASKS] = '{RA_MASK0, RA_MASK1, RA_MMASKA, RA_MMASKB};

   reg_addr_e    ra;
   logic         in_map;
   logic         wr_en;
   logic         rd_en;
   logic [W-1:0] mask_q [N_MASKS];
   logic [W-1:0] rd_mux;
   logic [W-1:0] rdata_q;

   assign ra     = reg_addr_e'(bus_addr[REG_SEL_W-1:0]);
   assign in_map = (bus_addr >> REG_SEL_W) == '0;
   assign wr_en  = bus_sel && bus_we && in_map;
   assign rd_en  = bus_sel && !bus_we;

   for (genvar m = 0; m < N_MASKS; m++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[m] <= '0;
         end else if (wr_en && (ra == MASK_AT[m])) begin
            mask_q[m] <= bus_wdata;
         end
      end
   end

   assign mask0   = mask_q[0];
   assign mask1   = mask_q[1];
   assign mmask_a = mask_q[2];
   assign mmask_b = mask_q[3];

   assign clr_stb  = wr_en && (ra == RA_TCLR);
   assign clr_bits = bus_wdata;

   always_comb begin
      rd_mux = '0;
      if (in_map) begin
         unique case (ra)
            RA_STAT0:  rd_mux = stat0;
            RA_MASK0:  rd_mux = mask_q[0];
            RA_STAT1:  rd_mux = stat1;
            RA_MASK1:  rd_mux = mask_q[1];
            RA_MSTAT:  rd_mux = mstat;
            RA_MMASKA: rd_mux = mask_q[2];
            RA_MMASKB: rd_mux = mask_q[3];
            RA_TCLR:   rd_mux = '0;
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
   import casc_irq_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CASC0_BIT = 7,
   parameter int unsigned CASC1_BIT = 3,
   parameter int unsigned TMR0_BIT  = 0,
   parameter int unsigned TMR1_BIT  = 1,
   parameter bit          IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic [W-1:0]      grp0_src,
   input  logic [W-1:0]      grp1_src,
   input  logic [W-1:0]      map_src,
   input  logic              tmr0_tick,
   input  logic              tmr1_tick,
   output logic              cpu_irq0,
   output logic              cpu_irq1
);

   localparam logic [W-1:0] INJ0 = W'(1) << CASC0_BIT;
   localparam logic [W-1:0] INJ1 = (W'(1) << CASC1_BIT) | (W'(1) << TMR0_BIT)
                                 | (W'(1) << TMR1_BIT);

   // Elaboration-time parameter checks
   if (W < N_TIMERS || W > 32) begin : g_bad_w
      $error("casc_irq_ctrl: W out of range");
   end
   if (ADDR_W < REG_SEL_W) begin : g_bad_addr
      $error("casc_irq_ctrl: ADDR_W too small for the register file");
   end
   if (CASC0_BIT >= W || CASC1_BIT >= W || TMR0_BIT >= W || TMR1_BIT >= W) begin : g_bad_pos
      $error("casc_irq_ctrl: injected bit position beyond W");
   end
   if (CASC1_BIT == TMR0_BIT || CASC1_BIT == TMR1_BIT || TMR0_BIT == TMR1_BIT) begin : g_bad_overlap
      $error("casc_irq_ctrl: group 1 injected bits overlap");
   end

   logic [W-1:0]             stat0;
   logic [W-1:0]             stat1;
   logic [W-1:0]             mask0;
   logic [W-1:0]             mask1;
   logic [W-1:0]             mmask_a;
   logic [W-1:0]             mmask_b;
   logic                     clr_stb;
   logic [W-1:0]             clr_bits;
   logic [N_TIMERS-1:0]      tflag;
   logic [N_CASC-1:0]        casc;
   logic [N_CASC-1:0][W-1:0] mmask_pk;
   logic [W-1:0]             inj0;
   logic [W-1:0]             inj1;

   assign mmask_pk[0] = mmask_a;
   assign mmask_pk[1] = mmask_b;

   casc_irq_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .stat0     (stat0),
      .stat1     (stat1),
      .mstat     (map_src),
      .mask0     (mask0),
      .mask1     (mask1),
      .mmask_a   (mmask_a),
      .mmask_b   (mmask_b),
      .clr_stb   (clr_stb),
      .clr_bits  (clr_bits)
   );

   casc_irq_cascade #(.W(W), .N_OUT(N_CASC)) u_casc (
      .mstat (map_src),
      .mmask (mmask_pk),
      .casc  (casc)
   );

   casc_irq_tick_latch #(.N(N_TIMERS)) u_ticks (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     ({tmr1_tick, tmr0_tick}),
      .clr_stb  (clr_stb),
      .clr_bits (clr_bits[N_TIMERS-1:0]),
      .flag     (tflag)
   );

   assign inj0 = W'(casc[0]) << CASC0_BIT;
   assign inj1 = (W'(casc[1]) << CASC1_BIT) | (W'(tflag[0]) << TMR0_BIT)
               | (W'(tflag[1]) << TMR1_BIT);

   casc_irq_group #(.W(W), .INJ_MASK(INJ0), .IRQ_REG(IRQ_REG)) u_grp0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (grp0_src),
      .inj_val (inj0),
      .mask    (mask0),
      .stat    (stat0),
      .irq     (cpu_irq0)
   );

   casc_irq_group #(.W(W), .INJ_MASK(INJ1), .IRQ_REG(IRQ_REG)) u_grp1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (grp1_src),
      .inj_val (inj1),
      .mask    (mask1),
      .stat    (stat1),
      .irq     (cpu_irq1)
   );

endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk #(
   parameter int unsigned W         = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CASC0_BIT = 7,
   parameter int unsigned CASC1_BIT = 3,
   parameter int unsigned TMR0_BIT  = 0,
   parameter bit          IRQ_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [W-1:0]      bus_rdata,
   input logic [W-1:0]      map_src,
   input logic              tmr0_tick,
   input logic              cpu_irq0,
   input logic [W-1:0]      mask0,
   input logic [W-1:0]      mmask_a,
   input logic [W-1:0]      mmask_b,
   input logic [W-1:0]      stat0,
   input logic [W-1:0]      stat1,
   input logic [1:0]        tflag
);

   logic wr_any;
   assign wr_any = bus_sel && bus_we;

   a_r2_cascade_a: assert property (@(posedge clk) disable iff (!rst_n)
      stat0[CASC0_BIT] == (|(map_src & mmask_a)));

   a_r3_cascade_b: assert property (@(posedge clk) disable iff (!rst_n)
      stat1[CASC1_BIT] == (|(map_src & mmask_b)));

   a_r4_mask0_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && bus_addr == ADDR_W'(1)) |=> $stable(mask0));

   if (IRQ_REG) begin : g_irq_chk
      a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(mask0) == '0) |-> !cpu_irq0);
   end

   a_r6_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tmr0_tick |=> (tflag[0] && stat1[TMR0_BIT]));

   a_r7_clear0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && bus_addr == ADDR_W'(7) && bus_wdata[0] && !tmr0_tick) |=> !tflag[0]);

   a_r7_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == ADDR_W'(7)) |=> bus_rdata == '0);

endmodule

bind casc_irq_ctrl casc_irq_chk #(
   .W(W), .ADDR_W(ADDR_W), .CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT),
   .TMR0_BIT(TMR0_BIT), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .map_src   (map_src),
   .tmr0_tick (tmr0_tick),
   .cpu_irq0  (cpu_irq0),
   .mask0     (mask0),
   .mmask_a   (mmask_a),
   .mmask_b   (mmask_b),
   .stat0     (stat0),
   .stat1     (stat1),
   .tflag     (tflag)
);

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] grp0_src = '0;
   logic [7:0] grp1_src = '0;
   logic [7:0] map_src = '0;
   logic       tmr0_tick = 1'b0;
   logic       tmr1_tick = 1'b0;
   logic       cpu_irq0;
   logic       cpu_irq1;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   casc_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .grp0_src(grp0_src), .grp1_src(grp1_src), .map_src(map_src),
      .tmr0_tick(tmr0_tick), .tmr1_tick(tmr1_tick),
      .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
   );

   typedef struct packed {
      logic [7:0] g0, g1, mp, m0, m1, ma, mb;
      logic       i0, i1;
   } vec_t;

   localparam int N_VEC = 7;
   localparam vec_t VEC [N_VEC] = '{
      '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0},
      '{8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},
      '{8'h80, 8'hF4, 8'h00, 8'h80, 8'hF7, 8'h00, 8'h00, 1'b0, 1'b1},
      '{8'h00, 8'h08, 8'h10, 8'h80, 8'h08, 8'h10, 8'h00, 1'b1, 1'b0},
      '{8'h00, 8'h00, 8'h24, 8'h80, 8'h08, 8'h04, 8'h20, 1'b1, 1'b1},
      '{8'h7F, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0},
      '{8'h40, 8'h02, 8'h00, 8'h40, 8'hFD, 8'h00, 8'h00, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_tick(input bit which);
      @(negedge clk);
      if (which) tmr1_tick = 1'b1; else tmr0_tick = 1'b1;
      @(negedge clk);
      tmr0_tick = 1'b0; tmr1_tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] e0, e1;

      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10", "irq0 in reset", cpu_irq0, 0);
      chk("R10", "irq1 in reset", cpu_irq1, 0);
      chk("R10", "rdata in reset", bus_rdata, 0);
      rst_n = 1'b1;
      for (int a = 1; a < 7; a += 2) begin
         rd(4'(a), d);
         chk("R10", "mask after reset", d, 0);
      end
      rd(4'd6, d); chk("R10", "map mask B after reset", d, 0);
      rd(4'd2, d); chk("R10", "timer flags after reset", d, 0);

      // Table walk: R1..R5
      for (int i = 0; i < N_VEC; i++) begin
         wr(4'd1, VEC[i].m0);
         wr(4'd3, VEC[i].m1);
         wr(4'd5, VEC[i].ma);
         wr(4'd6, VEC[i].mb);
         @(negedge clk);
         grp0_src = VEC[i].g0; grp1_src = VEC[i].g1; map_src = VEC[i].mp;
         @(negedge clk);
         chk("R5", $sformatf("vec %0d irq0", i), cpu_irq0, VEC[i].i0);
         chk("R5", $sformatf("vec %0d irq1", i), cpu_irq1, VEC[i].i1);
         e0 = {|(VEC[i].mp & VEC[i].ma), VEC[i].g0[6:0]};
         e1 = {VEC[i].g1[7:4], |(VEC[i].mp & VEC[i].mb), VEC[i].g1[2], 2'b00};
         rd(4'd0, d); chk("R2", $sformatf("vec %0d group0 status", i), d, e0);
         rd(4'd2, d); chk("R3", $sformatf("vec %0d group1 status", i), d, e1);
         rd(4'd4, d); chk("R4", $sformatf("vec %0d mapped status", i), d, VEC[i].mp);
         rd(4'd5, d); chk("R4", $sformatf("vec %0d map mask A", i), d, VEC[i].ma);
      end

      // R1: status writes ignored, level following
      @(negedge clk); grp0_src = 8'h05; grp1_src = 8'h00; map_src = 8'h00;
      wr(4'd0, 8'hFF); wr(4'd2, 8'hFF); wr(4'd4, 8'hFF);
      rd(4'd0, d); chk("R1", "group0 status after write", d, 8'h05);
      rd(4'd2, d); chk("R1", "group1 status after write", d, 8'h00);
      rd(4'd4, d); chk("R1", "mapped status after write", d, 8'h00);
      @(negedge clk); grp0_src = 8'h04;
      rd(4'd0, d); chk("R1", "busy bit drops with input", d, 8'h04);

      // R5: registered interrupt timing
      wr(4'd1, 8'h01); wr(4'd5, 8'h00);
      @(negedge clk); grp0_src = 8'h00;
      repeat (2) @(negedge clk);
      chk("R5", "irq0 idle", cpu_irq0, 0);
      @(posedge clk); #2 grp0_src = 8'h01;
      #13 chk("R5", "irq0 before edge", cpu_irq0, 0);
      @(posedge clk); #2 chk("R5", "irq0 after edge", cpu_irq0, 1);
      grp0_src = 8'h00;
      @(posedge clk); #2 chk("R5", "irq0 drops after edge", cpu_irq0, 0);

      // R6: timer flags
      wr(4'd3, 8'h00); wr(4'd6, 8'h00);
      @(negedge clk); grp1_src = 8'h03;
      rd(4'd2, d); chk("R6", "src on timer bits ignored", d, 8'h00);
      @(negedge clk); grp1_src = 8'h00;
      pulse_tick(1'b0);
      rd(4'd2, d); chk("R6", "tick0 sets bit 0", d, 8'h01);
      repeat (4) @(negedge clk);
      rd(4'd2, d); chk("R6", "flag0 sticky", d, 8'h01);
      wr(4'd3, 8'h01);
      @(negedge clk); chk("R6", "irq1 from timer flag", cpu_irq1, 1);
      pulse_tick(1'b1);
      rd(4'd2, d); chk("R6", "tick1 sets bit 1", d, 8'h03);

      // R7: clear register
      wr(4'd7, 8'h01);
      rd(4'd2, d); chk("R7", "clear bit 0 only", d, 8'h02);
      wr(4'd7, 8'hFC);
      rd(4'd2, d); chk("R7", "upper clear bits ignored", d, 8'h02);
      pulse_tick(1'b0);
      wr(4'd7, 8'h03);
      rd(4'd2, d); chk("R7", "clear both", d, 8'h00);
      rd(4'd7, d); chk("R7", "clear reads zero", d, 8'h00);

      // R8: tick and clear in the same cycle
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h01; tmr0_tick = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tmr0_tick = 1'b0;
      rd(4'd2, d); chk("R8", "tick wins over clear", d, 8'h01);
      wr(4'd7, 8'h03);

      // R9: address range and read data hold
      wr(4'd1, 8'h3C);
      wr(4'd9, 8'hAA);
      rd(4'd9, d); chk("R9", "high address reads zero", d, 8'h00);
      rd(4'd1, d); chk("R9", "high write leaves mask0", d, 8'h3C);
      repeat (3) @(negedge clk);
      chk("R9", "rdata holds without read", bus_rdata, 8'h3C);

      finish_run();
   end

endmodule